// File: doc/BRIEF.md
# Matrix-Unit Specialty Instruction Decoder

This block sits in front of a matrix-math unit and turns 32-bit instruction words into registered control actions. It handles a small group of specialty opcodes. Six retired opcodes once did convolution or pooling and now do no arithmetic. Two opcodes are matrix-multiply variants. One opcode requests an operand-B cache invalidate, one clears packer histograms, and two perform lane shifts. For every accepted word the block emits a one-hot operation select, forwards the fields the downstream datapath and address logic need, and reports the issue latency. The invalidate and histogram-clear requests are emitted as single-cycle pulses.

Words are offered with `in_valid` and taken on a clock edge where `in_ready` is high. Every output is registered. Each output is valid only in the cycle right after acceptance and returns to zero in the next cycle. The operand-B lane-shift opcode issues at half rate, so the block drops `in_ready` for the one cycle after it. A word that is not recognised is consumed, raises `illegal` for one cycle, and has no other effect.

Top module: `mxu_spec_decoder`

## Requirements
- R1: After reset, `out_valid`, `illegal`, `srcb_inval`, `hist_clr` and every field output are zero, and `in_ready` is high.
- R2: The retired opcodes (bits [31:24]) are 0x22, 0x23, 0x24, 0x25, 0x31 and 0x32. Each sets `op_sel` bit 0 and latency 5. Each forwards `dv_clr`=[23:22], `addr_sel`={4'b0,[15]} and `dst_idx`=[13:0]. None of them produces a pulse.
- R3: Opcode 0x29 sets `op_sel` bit 1 and forwards `addr_sel`=[18:14]. Opcode 0x34 sets `op_sel` bit 2 and forwards `addr_sel`={3'b0,[16:15]}. Both forward `dv_clr`=[23:22] and `dst_idx`=[13:0], and both have latency 5.
- R4: Opcode 0x35 sets `op_sel` bit 3 with latency 1. `srcb_inval` pulses for that one cycle exactly when bit 1 is set. Bit 0 has no effect.
- R5: Opcode 0x21 with bits [23:0] all zero sets `op_sel` bit 4 with latency 1 and pulses all bits of `hist_clr` together for one cycle. With any of bits [23:0] set, the word is treated as illegal.
- R6: Opcode 0x17 sets `op_sel` bit 5 with latency 1. Opcode 0x18 sets `op_sel` bit 6 with latency 2, and forwards `addr_sel`={4'b0,[15]} and `dst_idx`={4'b0,[9:0]}.
- R7: In the cycle after 0x18 is accepted, `in_ready` is low and a word offered then is not taken. That word is taken on the following edge.
- R8: An unrecognised opcode pulses `illegal` for one cycle. `out_valid`, `op_sel`, all fields and all pulses stay zero.
- R9: Outputs appear only in the cycle after acceptance and last one cycle. Without acceptance, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_word | input | 32 | Instruction word |
| in_ready | output | 1 | Word taken on this edge when high |
| out_valid | output | 1 | A recognised operation issued |
| op_sel | output | 7 | One-hot operation select |
| dv_clr | output | 2 | Data-valid clear code |
| addr_sel | output | 5 | Address-mode selector |
| dst_idx | output | 14 | Destination or row index |
| lat | output | 3 | Issue latency in cycles |
| srcb_inval | output | 1 | Operand-B cache invalidate pulse |
| hist_clr | output | NPK | Packer histogram clear pulse, one bit per packer |
| illegal | output | 1 | Unrecognised instruction pulse |

## Verification
The bubble after a 0x18 issue and a newly offered word fall in the same cycle. While `out_valid` still reports the 0x18, the next word is already waiting on `in_valid`. The bench provokes this by offering words back to back after each 0x18, including two 0x18 words in a row and an illegal word placed right behind one. It judges the result by checking that `in_ready` is low in exactly that cycle, that the held word's decode appears one cycle later than it would without the bubble, and that nothing from the held word appears early.

// File: rtl/mxu_spec_decoder.sv
module mxu_spec_decoder #(
  parameter int NPK   = 4,
  parameter int DST_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_word,
  output logic             in_ready,
  output logic             out_valid,
  output logic [6:0]       op_sel,
  output logic [1:0]       dv_clr,
  output logic [4:0]       addr_sel,
  output logic [DST_W-1:0] dst_idx,
  output logic [2:0]       lat,
  output logic             srcb_inval,
  output logic [NPK-1:0]   hist_clr,
  output logic             illegal
);

  logic [7:0]       opc;
  logic             fire, bubble;
  logic [6:0]       sel_d;
  logic [1:0]       dv_d;
  logic [4:0]       addr_d;
  logic [DST_W-1:0] dst_d;
  logic [2:0]       lat_d;
  logic             inval_d, hist_d, ill_d;

  assign opc      = in_word[31:24];
  assign in_ready = !bubble;
  assign fire     = in_valid && in_ready;

  always_comb begin
    sel_d   = '0;
    dv_d    = '0;
    addr_d  = '0;
    dst_d   = '0;
    lat_d   = '0;
    inval_d = 1'b0;
    hist_d  = 1'b0;
    ill_d   = 1'b0;
    case (opc)
      8'h22, 8'h23, 8'h24, 8'h25, 8'h31, 8'h32: begin
        sel_d[0] = 1'b1;
        dv_d     = in_word[23:22];
        addr_d   = {4'b0, in_word[15]};
        dst_d    = in_word[DST_W-1:0];
        lat_d    = 3'd5;
      end
      8'h29: begin
        sel_d[1] = 1'b1;
        dv_d     = in_word[23:22];
        addr_d   = in_word[18:14];
        dst_d    = in_word[DST_W-1:0];
        lat_d    = 3'd5;
      end
      8'h34: begin
        sel_d[2] = 1'b1;
        dv_d     = in_word[23:22];
        addr_d   = {3'b0, in_word[16:15]};
        dst_d    = in_word[DST_W-1:0];
        lat_d    = 3'd5;
      end
      8'h35: begin
        sel_d[3] = 1'b1;
        inval_d  = in_word[1];
        lat_d    = 3'd1;
      end
      8'h21: begin
        if (in_word[23:0] == 24'd0) begin
          sel_d[4] = 1'b1;
          hist_d   = 1'b1;
          lat_d    = 3'd1;
        end else begin
          ill_d = 1'b1;
        end
      end
      8'h17: begin
        sel_d[5] = 1'b1;
        lat_d    = 3'd1;
      end
      8'h18: begin
        sel_d[6] = 1'b1;
        addr_d   = {4'b0, in_word[15]};
        dst_d    = {{(DST_W-10){1'b0}}, in_word[9:0]};
        lat_d    = 3'd2;
      end
      default: ill_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bubble     <= 1'b0;
      out_valid  <= 1'b0;
      op_sel     <= '0;
      dv_clr     <= '0;
      addr_sel   <= '0;
      dst_idx    <= '0;
      lat        <= '0;
      srcb_inval <= 1'b0;
      hist_clr   <= '0;
      illegal    <= 1'b0;
    end else begin
      bubble     <= fire && sel_d[6];
      out_valid  <= fire && !ill_d;
      op_sel     <= fire ? sel_d : '0;
      dv_clr     <= fire ? dv_d : '0;
      addr_sel   <= fire ? addr_d : '0;
      dst_idx    <= fire ? dst_d : '0;
      lat        <= fire ? lat_d : '0;
      srcb_inval <= fire && inval_d;
      hist_clr   <= {NPK{fire && hist_d}};
      illegal    <= fire && ill_d;
    end
  end

endmodule

// File: rtl/mxu_spec_decoder_chk.sv
module mxu_spec_decoder_chk #(
  parameter int NPK   = 4,
  parameter int DST_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [31:0]      in_word,
  input logic             in_ready,
  input logic             out_valid,
  input logic [6:0]       op_sel,
  input logic [1:0]       dv_clr,
  input logic [4:0]       addr_sel,
  input logic [DST_W-1:0] dst_idx,
  input logic [2:0]       lat,
  input logic             srcb_inval,
  input logic [NPK-1:0]   hist_clr,
  input logic             illegal
);

  // R9
  no_fire_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> (!out_valid && !illegal && op_sel == '0));

  // R7
  shiftb_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_sel[6]) |-> !in_ready);

  // R8
  illegal_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!out_valid && op_sel == '0 && !srcb_inval && hist_clr == '0));

  // R4
  inval_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srcb_inval |-> (out_valid && op_sel[3]));

  // R5
  hist_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_clr != '0) |-> (hist_clr == {NPK{1'b1}} && op_sel[4] && lat == 3'd1));

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(op_sel) == 1));

  // R2
  retired_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_sel[0]) |-> (lat == 3'd5 && !srcb_inval && hist_clr == '0));

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srcb_inval && !$past(in_valid && in_ready)) |-> 1'b0);

endmodule

bind mxu_spec_decoder mxu_spec_decoder_chk #(.NPK(NPK), .DST_W(DST_W)) u_chk (.*);

// File: tb/mxu_spec_decoder_tb.sv
module mxu_spec_decoder_tb;
  localparam int NPK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        in_ready, out_valid, srcb_inval, illegal;
  logic [6:0]  op_sel;
  logic [1:0]  dv_clr;
  logic [4:0]  addr_sel;
  logic [13:0] dst_idx;
  logic [2:0]  lat;
  logic [NPK-1:0] hist_clr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [37:0] exp_bundle;
  logic        m_ready;
  string       exp_tag;

  always #2 clk = ~clk;

  mxu_spec_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .out_valid(out_valid), .op_sel(op_sel),
    .dv_clr(dv_clr), .addr_sel(addr_sel), .dst_idx(dst_idx), .lat(lat),
    .srcb_inval(srcb_inval), .hist_clr(hist_clr), .illegal(illegal)
  );

  function automatic logic [37:0] model(input logic [31:0] w, output string tag);
    int o;
    logic v; logic [6:0] s; logic [1:0] d; logic [4:0] a; logic [13:0] x;
    logic [2:0] l; logic iv; logic [3:0] h; logic il;
    o = int'(w[31:24]);
    v = 1; s = 0; d = 0; a = 0; x = 0; l = 0; iv = 0; h = 0; il = 0;
    if (o == 'h22 || o == 'h23 || o == 'h24 || o == 'h25 || o == 'h31 || o == 'h32) begin
      tag = "R2"; s = 7'd1; d = w[23:22]; a = {4'b0, w[15]}; x = w[13:0]; l = 5;
    end else if (o == 'h29) begin
      tag = "R3"; s = 7'd2; d = w[23:22]; a = w[18:14]; x = w[13:0]; l = 5;
    end else if (o == 'h34) begin
      tag = "R3"; s = 7'd4; d = w[23:22]; a = {3'b0, w[16:15]}; x = w[13:0]; l = 5;
    end else if (o == 'h35) begin
      tag = "R4"; s = 7'd8; iv = w[1]; l = 1;
    end else if (o == 'h21 && w[23:0] == 0) begin
      tag = "R5"; s = 7'd16; h = 4'hF; l = 1;
    end else if (o == 'h21) begin
      tag = "R5"; v = 0; il = 1;
    end else if (o == 'h17) begin
      tag = "R6"; s = 7'd32; l = 1;
    end else if (o == 'h18) begin
      tag = "R6"; s = 7'd64; a = {4'b0, w[15]}; x = {4'b0, w[9:0]}; l = 2;
    end else begin
      tag = "R8"; v = 0; il = 1;
    end
    return {v, s, d, a, x, l, iv, h, il};
  endfunction

  // one cycle: compare at negedge, then drive new inputs and advance the model
  task automatic cyc(input logic v, input logic [31:0] w, output logic took);
    logic [37:0] act;
    string t;
    @(negedge clk);
    act = {out_valid, op_sel, dv_clr, addr_sel, dst_idx, lat, srcb_inval, hist_clr, illegal};
    checks++;
    if (act !== exp_bundle) begin
      errors++;
      $display("FAIL %s: outputs actual=%h expected=%h", exp_tag, act, exp_bundle);
    end
    checks++;
    if (in_ready !== m_ready) begin
      errors++;
      $display("FAIL R7: in_ready actual=%b expected=%b", in_ready, m_ready);
    end
    in_valid = v;
    in_word  = w;
    took = v && m_ready;
    if (took) begin
      exp_bundle = model(w, t);
      exp_tag = t;
      m_ready = !(w[31:24] == 8'h18);
    end else begin
      exp_bundle = '0;
      exp_tag = m_ready ? "R9" : "R7";
      m_ready = 1'b1;
    end
  endtask

  task automatic send(input logic [31:0] w);
    logic took;
    took = 0;
    while (!took) cyc(1'b1, w, took);
  endtask

  task automatic idle(input int n);
    logic took;
    for (int i = 0; i < n; i++) cyc(1'b0, 32'h0, took);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    exp_bundle = '0;
    exp_tag = "R1";
    m_ready = 1'b1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    idle(2);                                       // R1 reset state
    // R2 retired opcodes with varied fields
    send(32'h22C0_8ABC); send(32'h2340_1FFF); send(32'h2480_0001);
    send(32'h2500_8000); send(32'h31FF_FFFF); send(32'h3200_0000);
    idle(1);
    // R3 multiply variants
    send(32'h29E7_C123); send(32'h2900_4000); send(32'h347F_8765); send(32'h3401_0000);
    // R4 invalidate, bit0 has no effect
    send(32'h3500_0003); send(32'h3500_0001); send(32'h3500_0002); send(32'h3500_0000);
    // R5 histogram clear and malformed variant
    send(32'h2100_0000); send(32'h2100_0010); send(32'h2180_0000); send(32'h2100_0000);
    // R6 lane shifts
    send(32'h1700_0003); send(32'h1800_87FF);
    // R7 bubble: back-to-back offers behind 0x18
    send(32'h2200_0005); send(32'h1800_0400); send(32'h1800_8001);
    send(32'hFF00_0000); send(32'h1800_0002); send(32'h3500_0002);
    // R8 unknown opcodes
    send(32'h0000_0000); send(32'h3000_0002); send(32'h2A12_3456); send(32'h1900_0000);
    idle(2);                                       // R9 quiet after activity
    lf = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      logic [7:0] pick [12] = '{8'h22, 8'h23, 8'h24, 8'h25, 8'h31, 8'h32,
                                8'h29, 8'h34, 8'h35, 8'h21, 8'h17, 8'h18};
      logic took;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[5:4] == 2'b00) cyc(1'b0, lf, took);
      else if (lf[7:6] == 2'b11) send({lf[31:24], 24'h0});
      else send({pick[lf[3:0] % 12], lf[23:0]});
    end
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule